// File: doc/BRIEF.md
# Sequential Loop Instruction Buffer

This block sits beside the fetch stage and keeps the last few instruction words that were fetched from consecutive addresses. It holds them as a single contiguous window, described by a base address and a valid count. Addresses count whole instruction words, so consecutive instructions sit at consecutive addresses.

Every ordinary fetch goes to memory. When the returned word continues the window, it is appended; otherwise the window restarts at the fetched address. When the fetch stage redirects to a branch target, the target is first compared against the window range. If it falls inside the range, the word comes straight from local storage with no memory access. This lets a short loop whose body fits in the window run without touching memory. A branch target outside the window is sent to memory, and the window is flushed and restarted at the target.

The block serves one request at a time. While a memory access is pending it lowers its ready output, and any fetch request presented in that time is dropped.

Top module: `seq_loop_buf`

## Requirements
- R1: Synchronous reset empties the window. After reset, no instruction is valid, no memory request is raised, ready is 1, and the first fetch (branch or not) goes to memory.
- R2: An accepted request that does not hit raises the memory request on the next cycle with the fetch address. Ready stays 0 until the response arrives.
- R3: A memory response sampled at a clock edge gives a one-cycle instruction-valid pulse right after that edge, with the hit flag 0 and the response word as the instruction. Ready returns to 1 in the same cycle.
- R4: A branch request (branch flag 1) whose address A satisfies (A - base) mod 2^AW < count hits. On the next cycle instruction-valid and the hit flag are 1 and the word stored for A is output, and no memory request is raised.
- R5: The window never holds more than DEPTH words. When a word is appended to a full window, the base moves up by one, so the oldest address then misses.
- R6: A branch miss flushes the window. Once the response is stored, the window holds only the target (count 1, base = target).
- R7: A non-branch fetch at address base + count appends its word. A non-branch fetch at any other address restarts the window at that address with count 1.
- R8: A fetch request presented while ready is 0 is ignored. The pending memory address stays unchanged and the window is not affected.
- R9: A hit leaves the window's base and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fetch_req_i | input | 1 | Fetch request, taken when fetch_ready_o is 1 |
| fetch_branch_i | input | 1 | 1: address is a branch target (window lookup); 0: sequential fetch |
| fetch_addr_i | input | AW | Instruction word address |
| fetch_ready_o | output | 1 | Block can take a request |
| mem_req_o | output | 1 | Memory read pending |
| mem_addr_o | output | AW | Address of the pending read |
| mem_rsp_valid_i | input | 1 | Memory returns the word for the pending read |
| mem_rsp_data_i | input | DW | Returned instruction word |
| instr_valid_o | output | 1 | One-cycle pulse: instruction delivered |
| instr_hit_o | output | 1 | Delivered word came from the window |
| instr_o | output | DW | Delivered instruction word |

## Verification
The assertions assume that memory raises its response valid only while a read is pending, and only for one cycle per read. They also assume a fetch request lasts one cycle. The bench's memory model answers only while mem_req_o is high, after a random delay of zero to three cycles. Each response word is computed from its address, so a word read from the wrong slot shows up in the data. During the delay the bench deliberately presents stray fetches, which exercises the busy-drop rule while staying within those assumptions.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } lbuf_state_e;

endpackage

// File: rtl/lbuf_window.sv
// Range check of an address against the buffered contiguous window.
module lbuf_window #(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [AW-1:0] addr_i,
    output logic          in_win_o,
    output logic          at_tail_o,
    output logic          full_o
);
    logic [AW-1:0] offset;

    always_comb begin
        offset    = addr_i - base_i;
        in_win_o  = offset < AW'(cnt_i);
        at_tail_o = addr_i == (base_i + AW'(cnt_i));
        full_o    = cnt_i == CW'(DEPTH);
    end
endmodule

// File: rtl/lbuf_store.sv
// Word storage, one slot per address modulo DEPTH.
module lbuf_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [IW-1:0] ridx_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic          wen;
        logic [DW-1:0] word_q;

        assign wen = we_i && (widx_i == IW'(i));

        always_ff @(posedge clk_i) begin
            if (wen) begin
                word_q <= wdata_i;
            end
        end

        assign words[i] = word_q;
    end

    assign rdata_o = words[ridx_i];
endmodule

// File: rtl/seq_loop_buf.sv
// Sequential loop instruction buffer: DEPTH must be a power of two, at least 2.
module seq_loop_buf
    import lbuf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          fetch_req_i,
    input  logic          fetch_branch_i,
    input  logic [AW-1:0] fetch_addr_i,
    output logic          fetch_ready_o,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_rsp_valid_i,
    input  logic [DW-1:0] mem_rsp_data_i,
    output logic          instr_valid_o,
    output logic          instr_hit_o,
    output logic [DW-1:0] instr_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        lbuf_state_e   st;
        logic [AW-1:0] base;
        logic [CW-1:0] cnt;
        logic [AW-1:0] req_addr;
        logic          req_app;
        logic          out_vld;
        logic          out_hit;
        logic [DW-1:0] out_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          in_win, at_tail, full;
    logic          st_we;
    logic [DW-1:0] st_rdata;

    lbuf_window #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_window (
        .base_i   (ctl_q.base),
        .cnt_i    (ctl_q.cnt),
        .addr_i   (fetch_addr_i),
        .in_win_o (in_win),
        .at_tail_o(at_tail),
        .full_o   (full)
    );

    lbuf_store #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_store (
        .clk_i  (clk_i),
        .we_i   (st_we),
        .widx_i (ctl_q.req_addr[IW-1:0]),
        .wdata_i(mem_rsp_data_i),
        .ridx_i (fetch_addr_i[IW-1:0]),
        .rdata_o(st_rdata)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.out_vld = 1'b0;
        ctl_d.out_hit = 1'b0;
        st_we         = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (fetch_req_i) begin
                    if (fetch_branch_i && in_win) begin
                        ctl_d.out_vld  = 1'b1;
                        ctl_d.out_hit  = 1'b1;
                        ctl_d.out_data = st_rdata;
                    end else begin
                        ctl_d.st       = ST_WAIT;
                        ctl_d.req_addr = fetch_addr_i;
                        ctl_d.req_app  = !fetch_branch_i && at_tail;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    st_we          = 1'b1;
                    ctl_d.st       = ST_IDLE;
                    ctl_d.out_vld  = 1'b1;
                    ctl_d.out_data = mem_rsp_data_i;
                    if (ctl_q.req_app) begin
                        if (full) begin
                            ctl_d.base = ctl_q.base + AW'(1);
                        end else begin
                            ctl_d.cnt = ctl_q.cnt + CW'(1);
                        end
                    end else begin
                        ctl_d.base = ctl_q.req_addr;
                        ctl_d.cnt  = CW'(1);
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q.st       <= ST_IDLE;
            ctl_q.base     <= '0;
            ctl_q.cnt      <= '0;
            ctl_q.req_addr <= '0;
            ctl_q.req_app  <= 1'b0;
            ctl_q.out_vld  <= 1'b0;
            ctl_q.out_hit  <= 1'b0;
            ctl_q.out_data <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fetch_ready_o = ctl_q.st == ST_IDLE;
    assign mem_req_o     = ctl_q.st == ST_WAIT;
    assign mem_addr_o    = ctl_q.req_addr;
    assign instr_valid_o = ctl_q.out_vld;
    assign instr_hit_o   = ctl_q.out_hit;
    assign instr_o       = ctl_q.out_data;
endmodule

// File: rtl/seq_loop_buf_chk.sv
module seq_loop_buf_chk #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          fetch_req_i,
    input logic          fetch_branch_i,
    input logic [AW-1:0] fetch_addr_i,
    input logic          fetch_ready_o,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_rsp_valid_i,
    input logic [DW-1:0] mem_rsp_data_i,
    input logic          instr_valid_o,
    input logic          instr_hit_o,
    input logic [DW-1:0] instr_o,
    input logic [CW-1:0] cnt_q
);
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= CW'(DEPTH)); // R5

    AST_HIT_FROM_BRANCH: assert property (@(posedge clk_i) disable iff (rst_i)
        (instr_valid_o && instr_hit_o) |-> ($past(fetch_req_i && fetch_branch_i && fetch_ready_o) && !mem_req_o)); // R4

    AST_MISS_ISSUES: assert property (@(posedge clk_i) disable iff (rst_i)
        (fetch_req_i && fetch_ready_o) |=> (mem_req_o || (instr_valid_o && instr_hit_o))); // R2

    AST_MISS_ADDR: assert property (@(posedge clk_i) disable iff (rst_i)
        (fetch_req_i && fetch_ready_o) |=> (!mem_req_o || (mem_addr_o == $past(fetch_addr_i)))); // R2

    AST_RSP_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_req_o && mem_rsp_valid_i) |=> (instr_valid_o && !instr_hit_o && fetch_ready_o && (instr_o == $past(mem_rsp_data_i)))); // R3

    AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_req_o |-> !fetch_ready_o); // R8

    AST_HIT_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
        (instr_valid_o && instr_hit_o) |-> $stable(cnt_q)); // R9

    AST_FILL_NONEMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
        (instr_valid_o && !instr_hit_o) |-> (cnt_q != '0)); // R6
endmodule

bind seq_loop_buf seq_loop_buf_chk #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)
) u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .fetch_req_i    (fetch_req_i),
    .fetch_branch_i (fetch_branch_i),
    .fetch_addr_i   (fetch_addr_i),
    .fetch_ready_o  (fetch_ready_o),
    .mem_req_o      (mem_req_o),
    .mem_addr_o     (mem_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i (mem_rsp_data_i),
    .instr_valid_o  (instr_valid_o),
    .instr_hit_o    (instr_hit_o),
    .instr_o        (instr_o),
    .cnt_q          (ctl_q.cnt)
);

// File: tb/seq_loop_buf_tb.sv
module seq_loop_buf_tb;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          fetch_req, fetch_branch;
    logic [AW-1:0] fetch_addr;
    logic          fetch_ready, mem_req;
    logic [AW-1:0] mem_addr;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          instr_valid, instr_hit;
    logic [DW-1:0] instr;

    int checks = 0;
    int fails  = 0;

    // reference window model
    logic [AW-1:0] m_base = '0;
    int            m_cnt  = 0;

    always #4 clk = ~clk;

    seq_loop_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk_i          (clk),
        .rst_i          (rst),
        .fetch_req_i    (fetch_req),
        .fetch_branch_i (fetch_branch),
        .fetch_addr_i   (fetch_addr),
        .fetch_ready_o  (fetch_ready),
        .mem_req_o      (mem_req),
        .mem_addr_o     (mem_addr),
        .mem_rsp_valid_i(rsp_valid),
        .mem_rsp_data_i (rsp_data),
        .instr_valid_o  (instr_valid),
        .instr_hit_o    (instr_hit),
        .instr_o        (instr)
    );

    function automatic logic [DW-1:0] memfn(logic [AW-1:0] a);
        return {a, ~a} ^ 32'h5A5A_0F0F;
    endfunction

    function automatic bit model_hit(logic [AW-1:0] a, bit br);
        logic [AW-1:0] off;
        off = a - m_base;
        return br && (int'(off) < m_cnt);
    endfunction

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one fetch, with memory response after a random delay when it misses
    task automatic do_fetch(logic [AW-1:0] a, bit br, string force_tag);
        bit    hit;
        bit    app;
        string tag;
        int    lat;
        hit = model_hit(a, br);
        app = !br && (a == m_base + AW'(m_cnt));
        if (force_tag != "")  tag = force_tag;
        else if (hit)         tag = "R4";
        else if (br)          tag = "R6";
        else if (app)         tag = "R7";
        else                  tag = "R7";
        @(negedge clk);
        fetch_req    = 1'b1;
        fetch_addr   = a;
        fetch_branch = br;
        @(negedge clk);
        fetch_req = 1'b0;
        if (hit) begin
            chk(tag, "hit valid", 32'(instr_valid), 32'd1);
            chk(tag, "hit flag", 32'(instr_hit), 32'd1);
            chk(tag, "hit data", instr, memfn(a));
            chk(tag, "hit no mem", 32'(mem_req), 32'd0);
        end else begin
            chk("R2", "mem_req", 32'(mem_req), 32'd1);
            chk("R2", "mem_addr", 32'(mem_addr), 32'(a));
            chk("R2", "ready low", 32'(fetch_ready), 32'd0);
            lat = $urandom_range(0, 3);
            for (int k = 0; k < lat; k++) begin
                fetch_req    = 1'b1;
                fetch_addr   = AW'($urandom);
                fetch_branch = 1'($urandom);
                @(negedge clk);
                fetch_req = 1'b0;
                chk("R8", "busy addr held", 32'(mem_addr), 32'(a));
                chk("R8", "busy req held", 32'(mem_req), 32'd1);
            end
            rsp_valid = 1'b1;
            rsp_data  = memfn(a);
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_data  = '0;
            chk("R3", "fill valid", 32'(instr_valid), 32'd1);
            chk("R3", "fill hit flag", 32'(instr_hit), 32'd0);
            chk("R3", "fill data", instr, memfn(a));
            chk("R3", "ready back", 32'(fetch_ready), 32'd1);
            if (app) begin
                if (m_cnt == DEPTH) m_base = m_base + AW'(1);
                else                m_cnt  = m_cnt + 1;
            end else begin
                m_base = a;
                m_cnt  = 1;
            end
        end
        @(negedge clk);
        chk("R3", "pulse one cycle", 32'(instr_valid), 32'd0);
    endtask

    initial begin
        logic [AW-1:0] last;
        int            r;
        void'($urandom(32'd20240611));
        rst          = 1'b1;
        fetch_req    = 1'b0;
        fetch_branch = 1'b0;
        fetch_addr   = '0;
        rsp_valid    = 1'b0;
        rsp_data     = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset valid", 32'(instr_valid), 32'd0);
        chk("R1", "reset mem_req", 32'(mem_req), 32'd0);
        chk("R1", "reset ready", 32'(fetch_ready), 32'd1);
        // R1: branch to 0 right after reset must miss although base is 0
        do_fetch(16'd0, 1'b1, "R1");

        // R5: fill past DEPTH, oldest drops
        for (int a = 100; a < 110; a++) do_fetch(AW'(a), 1'b0, "R7");
        do_fetch(16'd102, 1'b1, "R5");   // oldest kept word
        do_fetch(16'd109, 1'b1, "R9");   // newest, window untouched by previous hit
        do_fetch(16'd101, 1'b1, "R5");   // dropped -> miss, flush
        do_fetch(16'd102, 1'b1, "R6");   // flushed window holds only 101
        do_fetch(16'd103, 1'b0, "R7");   // append
        do_fetch(16'd102, 1'b1, "R4");
        do_fetch(16'd103, 1'b1, "R4");
        do_fetch(16'd110, 1'b0, "R7");   // discontinuity restarts
        do_fetch(16'd103, 1'b1, "R7");   // now a miss
        do_fetch(16'hFFFE, 1'b0, "R7");  // wrap around address space
        do_fetch(16'hFFFF, 1'b0, "R7");
        do_fetch(16'h0000, 1'b0, "R7");
        do_fetch(16'hFFFE, 1'b1, "R4");

        last = 16'd500;
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            bit            br;
            r = $urandom_range(0, 99);
            if (r < 55)      begin a = last + AW'(1); br = 1'b0; end
            else if (r < 82) begin a = last - AW'($urandom_range(0, 10)); br = 1'b1; end
            else if (r < 91) begin a = AW'($urandom); br = 1'b1; end
            else             begin a = last + AW'($urandom_range(2, 5)); br = 1'b0; end
            do_fetch(a, br, "");
            last = a;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule